// File: doc/BRIEF.md
# Byte-Lane Parallel EEPROM Write Sequencer

This block sits on the host side of a 32-bit parallel EEPROM module that is built from four byte-wide devices. The devices share the address lines and one output-enable. Each device has its own chip-select and write-enable. The host hands over one write at a time: an address, a data word, a per-lane enable mask and a flag that marks the final byte of a page. The sequencer then produces a write-enable-controlled write cycle. Every phase of that cycle (setup before the strobe falls, strobe low, hold after the strobe rises, strobe high between page bytes, and the device programming time after the page) lasts at least a parameterised number of clock cycles.

Several bytes of one page can be streamed back to back. Between them the strobe stays high for the minimum recovery time. When the byte flagged as final has been strobed, the sequencer keeps the bus idle for the whole programming time. It then raises a one-cycle completion pulse and accepts a new request. Reading back and end-of-write polling are not part of this block. A fixed wait replaces them.

Top module: `eeprom_page_writer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every chip-select and write-enable output is high (inactive), `req_ready` is high and `wr_done` is low.
- R2: `mem_oe_n` is high in every cycle, so the memory never drives the shared data lines.
- R3: Bit i of `req_lanes` enables lane i, which drives `mem_cs_n[i]`, `mem_we_n[i]` and data bits 8i+7..8i. Only enabled lanes drive their chip-select and write-enable low. Disabled lanes keep both signals high. A mask of zero still runs the full timing sequence but strobes no lane.
- R4: From the cycle after a request is accepted, the enabled chip-selects are low and the address and data are driven for exactly SETUP_CYC cycles before any write-enable falls.
- R5: The enabled write-enables stay low for exactly PULSE_CYC consecutive cycles per request.
- R6: After the write-enables rise, the chip-selects stay low and the address and data stay unchanged for HOLD_CYC more cycles.
- R7: A lane's write-enable is low only in cycles in which the same lane's chip-select is low.
- R8: The address and data outputs do not change in any cycle in which a chip-select is low. They equal the values captured from the accepted request.
- R9: After a byte without the final flag, all lanes are deselected and `req_ready` rises in the GAP_CYC-th cycle after the hold phase. It stays high until the next request arrives.
- R10: After a byte with the final flag, all lanes are deselected and `req_ready` stays low for PROG_CYC cycles. `wr_done` is then high for exactly one cycle, together with `req_ready`.
- R11: `req_ready` is low from the cycle after acceptance until the gap or completion cycle. Requests presented in that time are ignored and do not alter the outputs.
- R12: A request is taken on a rising edge where `req_valid` and `req_ready` are both high. Its address, data, mask and final flag are captured on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Sequencer can take a request |
| req_addr | input | ADDR_W | Word address of the write |
| req_data | input | LANES*LANE_W | Data word |
| req_lanes | input | LANES | Per-lane enable mask |
| req_last | input | 1 | Final byte of a page; programming wait follows |
| wr_done | output | 1 | One-cycle pulse when the programming wait ends |
| mem_addr | output | ADDR_W | Shared address lines |
| mem_data | output | LANES*LANE_W | Data lines toward the memory |
| mem_cs_n | output | LANES | Per-lane chip-select, active low |
| mem_we_n | output | LANES | Per-lane write-enable, active low |
| mem_oe_n | output | 1 | Shared output-enable, held inactive |

## Verification
The embedded properties check the following on every cycle:
- disabled lanes stay inactive;
- a write-enable is never low without its chip-select;
- the address is stable while any lane is selected;
- the strobe width is at least PULSE_CYC;
- `req_ready` is never high during a strobe;
- `wr_done` lasts one cycle and follows only the programming phase.

Exact phase lengths, the release of `req_ready` after a gap or a programming wait, the ignoring of requests while busy, and acceptance in the very cycle of the completion pulse are shown by the bench. It compares every output against a per-cycle expected trace built from the requirements, across full masks, partial masks, an empty mask, multi-byte pages with and without host stalls, and back-to-back pages.

// File: rtl/ewr_pkg.sv
`timescale 1ns/1ps
package ewr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_GAP,
        ST_PROG
    } ewr_state_e;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int at_least_one(input int v);
        return (v < 1) ? 1 : v;
    endfunction

endpackage

// File: rtl/ewr_phase_timer.sv
`timescale 1ns/1ps
module ewr_phase_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             zero_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero_o = (cnt_q == '0);

    // R4
    timer_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt_q == '0) |=> (cnt_q == '0));

endmodule

// File: rtl/ewr_lane_ctl.sv
`timescale 1ns/1ps
module ewr_lane_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_i,
    input  logic stb_i,
    input  logic en_i,
    output logic cs_n_o,
    output logic we_n_o
);

    typedef struct packed {
        logic cs_n;
        logic we_n;
    } lane_t;

    lane_t lane_d, lane_q;

    always_comb begin
        lane_d.cs_n = !(sel_i && en_i);
        lane_d.we_n = !(stb_i && en_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lane_q <= '{cs_n: 1'b1, we_n: 1'b1};
        end else begin
            lane_q <= lane_d;
        end
    end

    assign cs_n_o = lane_q.cs_n;
    assign we_n_o = lane_q.we_n;

    // R7
    we_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n_o |-> !cs_n_o);

endmodule

// File: rtl/eeprom_page_writer.sv
`timescale 1ns/1ps
module eeprom_page_writer
    import ewr_pkg::*;
#(
    parameter int ADDR_W    = 15,
    parameter int LANES     = 4,
    parameter int LANE_W    = 8,
    parameter int SETUP_CYC = 2,
    parameter int PULSE_CYC = 30,
    parameter int HOLD_CYC  = 20,
    parameter int GAP_CYC   = 10,
    parameter int PROG_CYC  = 2000000
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic [ADDR_W-1:0]         req_addr,
    input  logic [LANES*LANE_W-1:0]   req_data,
    input  logic [LANES-1:0]          req_lanes,
    input  logic                      req_last,
    output logic                      wr_done,
    output logic [ADDR_W-1:0]         mem_addr,
    output logic [LANES*LANE_W-1:0]   mem_data,
    output logic [LANES-1:0]          mem_cs_n,
    output logic [LANES-1:0]          mem_we_n,
    output logic                      mem_oe_n
);

    localparam int DATA_W = LANES * LANE_W;
    localparam int S_EFF  = at_least_one(SETUP_CYC);
    localparam int P_EFF  = at_least_one(PULSE_CYC);
    localparam int H_EFF  = at_least_one(HOLD_CYC);
    localparam int GP_EFF = at_least_one(GAP_CYC);
    localparam int PR_EFF = at_least_one(PROG_CYC);
    localparam int MAX_C  = max_of(max_of(max_of(S_EFF, P_EFF), max_of(H_EFF, GP_EFF)), PR_EFF);
    localparam int CNT_W  = $clog2(MAX_C + 1);

    localparam logic [CNT_W-1:0] LD_SETUP = CNT_W'(S_EFF - 1);
    localparam logic [CNT_W-1:0] LD_PULSE = CNT_W'(P_EFF - 1);
    localparam logic [CNT_W-1:0] LD_HOLD  = CNT_W'(H_EFF - 1);
    localparam logic [CNT_W-1:0] LD_GAP   = CNT_W'(GP_EFF - 1);
    localparam logic [CNT_W-1:0] LD_PROG  = CNT_W'(PR_EFF - 1);

    typedef struct packed {
        ewr_state_e          st;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   data;
        logic [LANES-1:0]    mask;
        logic                last;
        logic                done;
    } ctl_t;

    ctl_t             ctl_d, ctl_q;
    logic             t_load;
    logic [CNT_W-1:0] t_val;
    logic             t_zero;
    logic             take;
    logic             sel_d, stb_d;

    // ---------------------------------------------------------------
    // Phase timer: one down-counter reloaded at each phase entry
    // ---------------------------------------------------------------
    ewr_phase_timer #(.CNT_W(CNT_W)) timer_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (t_load),
        .load_val_i (t_val),
        .zero_o     (t_zero)
    );

    always_comb begin
        req_ready = (ctl_q.st == ST_IDLE) || ((ctl_q.st == ST_GAP) && t_zero);
        take      = req_valid && req_ready;
    end

    // ---------------------------------------------------------------
    // Next-state computation
    // ---------------------------------------------------------------
    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        t_load     = 1'b0;
        t_val      = '0;

        unique case (ctl_q.st)
            ST_IDLE, ST_GAP: begin
                if (take) begin
                    ctl_d.st   = ST_SETUP;
                    ctl_d.addr = req_addr;
                    ctl_d.data = req_data;
                    ctl_d.mask = req_lanes;
                    ctl_d.last = req_last;
                    t_load     = 1'b1;
                    t_val      = LD_SETUP;
                end
            end
            ST_SETUP: begin
                if (t_zero) begin
                    ctl_d.st = ST_STROBE;
                    t_load   = 1'b1;
                    t_val    = LD_PULSE;
                end
            end
            ST_STROBE: begin
                if (t_zero) begin
                    ctl_d.st = ST_HOLD;
                    t_load   = 1'b1;
                    t_val    = LD_HOLD;
                end
            end
            ST_HOLD: begin
                if (t_zero) begin
                    t_load = 1'b1;
                    if (ctl_q.last) begin
                        ctl_d.st = ST_PROG;
                        t_val    = LD_PROG;
                    end else begin
                        ctl_d.st = ST_GAP;
                        t_val    = LD_GAP;
                    end
                end
            end
            ST_PROG: begin
                if (t_zero) begin
                    ctl_d.st   = ST_IDLE;
                    ctl_d.done = 1'b1;
                end
            end
            default: begin
                ctl_d.st = ST_IDLE;
            end
        endcase

        sel_d = (ctl_d.st == ST_SETUP) || (ctl_d.st == ST_STROBE) || (ctl_d.st == ST_HOLD);
        stb_d = (ctl_d.st == ST_STROBE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, addr: '0, data: '0, mask: '0, last: 1'b0, done: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    // ---------------------------------------------------------------
    // Per-lane strobe registers
    // ---------------------------------------------------------------
    for (genvar li = 0; li < LANES; li++) begin : g_lane
        ewr_lane_ctl lane_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .sel_i  (sel_d),
            .stb_i  (stb_d),
            .en_i   (ctl_d.mask[li]),
            .cs_n_o (mem_cs_n[li]),
            .we_n_o (mem_we_n[li])
        );

        // R3
        idle_lane_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !ctl_q.mask[li] |-> (mem_cs_n[li] && mem_we_n[li]));
    end

    assign mem_addr = ctl_q.addr;
    assign mem_data = ctl_q.data;
    assign mem_oe_n = 1'b1;
    assign wr_done  = ctl_q.done;

    // ---------------------------------------------------------------
    // Checks
    // ---------------------------------------------------------------
    logic             any_sel, any_stb;
    logic [CNT_W:0]   low_run_q;

    assign any_sel = ~&mem_cs_n;
    assign any_stb = ~&mem_we_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run_q <= '0;
        end else if (any_stb) begin
            if (low_run_q != '1) low_run_q <= low_run_q + 1'b1;
        end else begin
            low_run_q <= '0;
        end
    end

    // R5
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(any_stb) |-> (low_run_q >= (CNT_W+1)'(P_EFF)));

    // R8
    addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (any_sel && $past(any_sel)) |-> ($stable(mem_addr) && $stable(mem_data)));

    // R11
    busy_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_stb |-> !req_ready);

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |=> !wr_done);

    // R10
    done_after_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_done) |-> ($past(ctl_q.st) == ST_PROG));

endmodule

// File: tb/eeprom_page_writer_tb.sv
`timescale 1ns/1ps
module eeprom_page_writer_tb_top;

    localparam int S  = 2;
    localparam int P  = 3;
    localparam int H  = 2;
    localparam int GP = 3;
    localparam int G  = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [14:0] req_addr = '0;
    logic [31:0] req_data = '0;
    logic [3:0]  req_lanes = '0;
    logic        req_last = 1'b0;
    logic        wr_done;
    logic [14:0] mem_addr;
    logic [31:0] mem_data;
    logic [3:0]  mem_cs_n;
    logic [3:0]  mem_we_n;
    logic        mem_oe_n;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    eeprom_page_writer #(
        .ADDR_W(15), .LANES(4), .LANE_W(8),
        .SETUP_CYC(S), .PULSE_CYC(P), .HOLD_CYC(H), .GAP_CYC(GP), .PROG_CYC(G)
    ) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_data(req_data), .req_lanes(req_lanes), .req_last(req_last),
        .wr_done(wr_done),
        .mem_addr(mem_addr), .mem_data(mem_data),
        .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n)
    );

    // ---------------- reference model: queue of expected cycles -------------
    typedef struct {
        logic [3:0] cs;
        logic [3:0] we;
        logic       rdy;
        logic       done;
        logic       chk;
        int         tag;
    } exp_t;

    exp_t        q[$];
    bit          in_page = 1'b0;
    logic [14:0] e_addr = '0;
    logic [31:0] e_data = '0;

    function automatic exp_t cur_exp();
        exp_t e;
        if (q.size() != 0) return q[0];
        e.cs = 4'hF; e.we = 4'hF; e.rdy = 1'b1; e.done = 1'b0; e.chk = 1'b0;
        e.tag = in_page ? 9 : 12;
        return e;
    endfunction

    function automatic exp_t mk(logic [3:0] cs, logic [3:0] we, logic rdy, logic done,
                                logic chk, int tag);
        exp_t e;
        e.cs = cs; e.we = we; e.rdy = rdy; e.done = done; e.chk = chk; e.tag = tag;
        return e;
    endfunction

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s at %0t: actual=%h expected=%h", req, what, $time, act, exp);
        end
    endtask

    // compare away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            exp_t c;
            c = cur_exp();
            // R3 lane chip-selects follow the mask
            check(mem_cs_n == c.cs, "R3", "cs_n", 32'(mem_cs_n), 32'(c.cs));
            // R4 R5 R6 R7 R9 R10 R12: strobe per phase (tag of the phase)
            check(mem_we_n == c.we, $sformatf("R%0d R7", c.tag), "we_n", 32'(mem_we_n), 32'(c.we));
            check(mem_oe_n == 1'b1, "R2", "oe_n", 32'(mem_oe_n), 32'd1);
            check(req_ready == c.rdy, "R11 R12", "ready", 32'(req_ready), 32'(c.rdy));
            check(wr_done == c.done, "R10", "done", 32'(wr_done), 32'(c.done));
            if (c.chk) begin
                check(mem_addr == e_addr, "R8", "addr", 32'(mem_addr), 32'(e_addr));
                check(mem_data == e_data, "R8", "data", mem_data, e_data);
            end
        end
    end

    // advance the model on the edge
    always @(posedge clk) begin
        if (rst_n) begin
            exp_t c;
            c = cur_exp();
            if (q.size() != 0) void'(q.pop_front());
            if (req_valid && c.rdy) begin
                // R12 capture
                e_addr = req_addr;
                e_data = req_data;
                for (int i = 0; i < S; i++) q.push_back(mk(~req_lanes, 4'hF, 1'b0, 1'b0, 1'b1, 4));
                for (int i = 0; i < P; i++) q.push_back(mk(~req_lanes, ~req_lanes, 1'b0, 1'b0, 1'b1, 5));
                for (int i = 0; i < H; i++) q.push_back(mk(~req_lanes, 4'hF, 1'b0, 1'b0, 1'b1, 6));
                if (req_last) begin
                    for (int i = 0; i < G; i++) q.push_back(mk(4'hF, 4'hF, 1'b0, 1'b0, 1'b0, 10));
                    q.push_back(mk(4'hF, 4'hF, 1'b1, 1'b1, 1'b0, 10));
                    in_page = 1'b0;
                end else begin
                    for (int i = 0; i < GP - 1; i++) q.push_back(mk(4'hF, 4'hF, 1'b0, 1'b0, 1'b0, 9));
                    in_page = 1'b1;
                end
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic send(logic [14:0] a, logic [31:0] d, logic [3:0] m, logic l);
        bit acc;
        req_addr = a; req_data = d; req_lanes = m; req_last = l;
        req_valid = 1'b1;
        forever begin
            acc = req_ready;
            @(negedge clk);
            if (acc) break;
        end
        req_valid = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(mem_cs_n == 4'hF, "R1", "cs_n in reset", 32'(mem_cs_n), 32'hF);
        check(mem_we_n == 4'hF, "R1", "we_n in reset", 32'(mem_we_n), 32'hF);
        check(req_ready == 1'b1, "R1", "ready in reset", 32'(req_ready), 32'd1);
        check(wr_done == 1'b0, "R1", "done in reset", 32'(wr_done), 32'd0);
        rst_n = 1'b1;
        idle(2);

        // single full-width final write
        send(15'h1234, 32'hDEADBEEF, 4'b1111, 1'b1);
        // R11: requests while busy are ignored
        req_addr = 15'h7FFF; req_data = 32'h0BAD0BAD; req_lanes = 4'b0101; req_last = 1'b0;
        req_valid = 1'b1;
        idle(5);
        req_valid = 1'b0;
        idle(G + 4);

        // R3 R9: page of three bytes with partial masks and a host stall
        send(15'h0040, 32'h11223344, 4'b0001, 1'b0);
        send(15'h0041, 32'h55667788, 4'b1010, 1'b0);
        idle(4);
        send(15'h0042, 32'h99AABBCC, 4'b0110, 1'b1);
        idle(G + 4);

        // R3: empty mask still runs the sequence
        send(15'h0100, 32'hCAFEF00D, 4'b0000, 1'b1);
        idle(G + 4);

        // R10 R12: back-to-back pages, second taken in the done cycle
        send(15'h0200, 32'h01020304, 4'b1000, 1'b1);
        send(15'h0201, 32'hA5A5A5A5, 4'b0011, 1'b1);
        idle(G + 6);

        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL R10 watchdog: actual=running expected=finished");
        summary();
        $finish;
    end

endmodule